// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator with Line-Locked Frequency Update

This block produces the colour subcarrier as a pair of signed quadrature samples. A 32-bit phase accumulator steps once per clock by a frequency word. The top ten phase bits, shifted by a programmable 8-bit offset, address a computed sine/cosine shaping function. The registered sine and cosine samples then feed a chroma modulator placed downstream.

One shared serial pin gives the accumulator two ways to follow an external timing source. The pin mode selects between them. In the line-locked mode, a serial receiver takes framed words from a video decoder. Each word supplies a new upper increment, a line-inversion flag and an accumulator-clear flag, and all three take effect at the next line start. In the field-rephase mode, a rising edge on the pin arms a one-shot clear of the accumulator, which fires on the next field-start strobe.

Top module: `subcarrier_dds`

## Requirements
- R1: A 32-bit accumulator adds the active increment on every clock. The lookup phase is accumulator bits [31:22] plus the offset shifted left by two, taken modulo 1024.
- R2: For a 10-bit phase p, let x = p[7:0] and y = (p[8] ? 256-x : x). The magnitude is floor(y*(512-y)/256), and the sign is negative when p[9] is 1. The sine output is this value for p, registered, so it appears one clock after the accumulator value it was computed from.
- R3: The cosine output uses the same function at phase p+256 (modulo 1024).
- R4: The pin mode encodings are 00 and 11 = pin ignored, 01 = field rephase, 10 = line-locked. In every mode except line-locked, the increment is the 32-bit frequency word.
- R5: In field-rephase mode, a rising edge on the pin arms a clear. The accumulator is then set to 0 on the next clock edge that sees the field-start strobe high, and not before. One arm gives exactly one clear.
- R6: In line-locked mode, a frame begins when the pin falls after being high for at least one clock. A 2-clock start slot follows, then 67 data bits, each 2 clocks long and sampled on its second clock. Bits 0..21 are the increment (least significant first), bit 22 is the inversion flag and bit 23 is the clear flag.
- R7: A received word is held until the next line-start strobe in line-locked mode. From the clock after that strobe, the increment is {word bits 21:0, frequency word bits 9:0}.
- R8: If the clear flag of the applied word is 1, the accumulator is set to 0 at that line-start edge.
- R9: When the applied inversion flag is 1, the PAL select is 1 and the mode is line-locked, the cosine output is negated. With the PAL select at 0, the flag has no effect.
- R10: If the pin mode leaves line-locked during a frame, the frame is dropped and the active increment stays unchanged.
- R11: Synchronous reset clears the accumulator, both outputs, the held word, the received increment and the inversion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one accumulator step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rtc_pin | input | 1 | Shared serial-frame / rephase pin |
| pin_mode | input | 2 | Pin function select |
| pal_mode | input | 1 | 1 = PAL line inversion honoured |
| freq_word | input | 32 | Programmed frequency increment |
| phase_ofs | input | 8 | Phase offset added above bit 22 |
| line_start | input | 1 | One-cycle strobe at each line start |
| field_start | input | 1 | One-cycle strobe at each field start |
| sin_out | output | 10 | Signed sine sample |
| cos_out | output | 10 | Signed cosine sample |

## Verification
Several properties hold on every cycle and are checked there: the amplitude bound of both outputs, the quadrature relation at sine zero crossings, the retention of an armed rephase until a field strobe, and the accumulator step. The receiver is also checked every cycle for frame completion and for abort on a mode change. The placement of frame bits, the delay of a new increment until the line start, the clear flag, the PAL-only inversion and dropped frames can only be shown by the bench scenarios. For these, a behavioural model replays the pin history and is compared with the outputs on every clock.

// File: rtl/sc_dds_pkg.sv
package sc_dds_pkg;
    localparam int ACC_W     = 32;
    localparam int PH_W      = 10;
    localparam int OFS_W     = 8;
    localparam int RTC_BITS  = 67;
    localparam int RTC_INC_W = 22;
    localparam int SEQ_POS   = 22;
    localparam int CLR_POS   = 23;
    localparam int CAP_W     = CLR_POS + 1;
    localparam int IDX_W     = $clog2(RTC_BITS);
    localparam int QW        = PH_W - 2;
    localparam int QTR       = 1 << QW;
    localparam int PRD_W     = 2 * QW + 2;
    localparam int LOW_W     = ACC_W - RTC_INC_W;

    typedef enum logic [1:0] {
        PIN_IDLE  = 2'b00,
        PIN_SCR   = 2'b01,
        PIN_RTC   = 2'b10,
        PIN_IDLE2 = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic [RTC_INC_W-1:0] inc;
        logic                 seq;
        logic                 clr;
    } rtc_word_t;

    // Quarter-parabola shaping of a phase into a signed amplitude.
    function automatic logic signed [PH_W-1:0] wave(input logic [PH_W-1:0] ph);
        logic [QW:0]       y;
        logic [PRD_W-1:0]  prod;
        logic [QW+1:0]     mag;
        y    = ph[QW] ? ((QW+1)'(QTR) - (QW+1)'(ph[QW-1:0])) : (QW+1)'(ph[QW-1:0]);
        prod = PRD_W'(y) * PRD_W'((QW+2)'(2 * QTR) - (QW+2)'(y));
        mag  = (QW+2)'(prod >> QW);
        return ph[PH_W-1] ? -$signed(mag) : $signed(mag);
    endfunction
endpackage

// File: rtl/sc_rtc_rx.sv
module sc_rtc_rx
    import sc_dds_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      pin,
    input  logic      pin_q,
    output logic      done,
    output rtc_word_t word
);
    logic             busy;
    logic             half;
    logic             in_start;
    logic [IDX_W-1:0] idx;
    logic [CAP_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            half     <= 1'b0;
            in_start <= 1'b0;
            idx      <= '0;
            shreg    <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (!en) begin
                    busy <= 1'b0;
                end else begin
                    half <= ~half;
                    if (half) begin
                        if (in_start) begin
                            in_start <= 1'b0;
                        end else begin
                            if (idx < IDX_W'(CAP_W))
                                shreg <= {pin, shreg[CAP_W-1:1]};
                            if (idx == IDX_W'(RTC_BITS - 1)) begin
                                busy <= 1'b0;
                                done <= 1'b1;
                            end
                            idx <= idx + 1'b1;
                        end
                    end
                end
            end else if (en && pin_q && !pin) begin
                busy     <= 1'b1;
                half     <= 1'b1;
                in_start <= 1'b1;
                idx      <= '0;
            end
        end
    end

    assign word.inc = shreg[RTC_INC_W-1:0];
    assign word.seq = shreg[SEQ_POS];
    assign word.clr = shreg[CLR_POS];

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    p_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !en) |=> (!busy && !done));
endmodule

// File: rtl/sc_phase_acc.sv
module sc_phase_acc
    import sc_dds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] inc,
    input  logic             scr_en,
    input  logic             pin,
    input  logic             pin_q,
    input  logic             field_start,
    input  logic             line_clr,
    output logic [ACC_W-1:0] acc
);
    logic armed;
    logic fire;
    logic rise;

    assign fire = scr_en && armed && field_start;
    assign rise = scr_en && !pin_q && pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            armed <= 1'b0;
        end else begin
            if (fire || line_clr) acc <= '0;
            else                  acc <= acc + inc;
            if (rise)      armed <= 1'b1;
            else if (fire) armed <= 1'b0;
        end
    end

    p_acc_step_r1: assert property (@(posedge clk) disable iff (rst)
        !(fire || line_clr) |=> acc == $past(acc + inc));
    p_arm_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && !field_start) |=> armed);
    p_fire_zero_r5: assert property (@(posedge clk) disable iff (rst)
        fire |=> acc == '0);
endmodule

// File: rtl/sc_wave_lut.sv
module sc_wave_lut
    import sc_dds_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PH_W-1:0]        phase,
    input  logic                   invert,
    output logic signed [PH_W-1:0] sin_q,
    output logic signed [PH_W-1:0] cos_q
);
    logic [PH_W-1:0]        cph;
    logic signed [PH_W-1:0] s_c;
    logic signed [PH_W-1:0] c_c;

    assign cph = phase + PH_W'(QTR);

    always_comb begin
        s_c = wave(phase);
        c_c = wave(cph);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_q <= '0;
            cos_q <= '0;
        end else begin
            sin_q <= s_c;
            cos_q <= invert ? -c_c : c_c;
        end
    end

    p_amp_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(sin_q) <= QTR) && (int'(sin_q) >= -QTR)
        && (int'(cos_q) <= QTR) && (int'(cos_q) >= -QTR));
    p_quadrature_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && sin_q == '0) |-> (int'(cos_q) == QTR || int'(cos_q) == -QTR));
endmodule

// File: rtl/subcarrier_dds.sv
module subcarrier_dds
    import sc_dds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rtc_pin,
    input  logic [1:0]        pin_mode,
    input  logic              pal_mode,
    input  logic [31:0]       freq_word,
    input  logic [7:0]        phase_ofs,
    input  logic              line_start,
    input  logic              field_start,
    output logic signed [9:0] sin_out,
    output logic signed [9:0] cos_out
);
    pin_mode_e            mode;
    logic                 rtc_en;
    logic                 scr_en;
    logic                 pin_q;
    logic                 rx_done;
    rtc_word_t            rx_word;
    rtc_word_t            pend;
    logic                 pend_v;
    logic [RTC_INC_W-1:0] line_inc;
    logic                 line_seq;
    logic                 apply;
    logic                 line_clr;
    logic [ACC_W-1:0]     inc;
    logic [ACC_W-1:0]     acc;
    logic [PH_W-1:0]      phase;
    logic                 invert;

    assign mode     = pin_mode_e'(pin_mode);
    assign rtc_en   = (mode == PIN_RTC);
    assign scr_en   = (mode == PIN_SCR);
    assign apply    = rtc_en && line_start && pend_v;
    assign line_clr = apply && pend.clr;
    assign inc      = rtc_en ? {line_inc, freq_word[LOW_W-1:0]} : freq_word;
    assign phase    = acc[ACC_W-1:ACC_W-PH_W] + {phase_ofs, {(PH_W-OFS_W){1'b0}}};
    assign invert   = pal_mode && line_seq && rtc_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q    <= 1'b0;
            pend     <= '0;
            pend_v   <= 1'b0;
            line_inc <= '0;
            line_seq <= 1'b0;
        end else begin
            pin_q <= rtc_pin;
            if (apply) begin
                line_inc <= pend.inc;
                line_seq <= pend.seq;
            end
            if (rx_done) begin
                pend_v <= 1'b1;
                pend   <= rx_word;
            end else if (apply) begin
                pend_v <= 1'b0;
            end
        end
    end

    sc_rtc_rx u_rx (
        .clk   (clk),
        .rst   (rst),
        .en    (rtc_en),
        .pin   (rtc_pin),
        .pin_q (pin_q),
        .done  (rx_done),
        .word  (rx_word)
    );

    sc_phase_acc u_acc (
        .clk         (clk),
        .rst         (rst),
        .inc         (inc),
        .scr_en      (scr_en),
        .pin         (rtc_pin),
        .pin_q       (pin_q),
        .field_start (field_start),
        .line_clr    (line_clr),
        .acc         (acc)
    );

    sc_wave_lut u_lut (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .invert (invert),
        .sin_q  (sin_out),
        .cos_q  (cos_out)
    );

    p_pend_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (pend_v && !apply && !rx_done) |=> pend_v);
    p_inc_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (rtc_en && !apply && $past(rtc_en)) |=> $stable(line_inc));
endmodule

// File: tb/subcarrier_dds_test.sv
module subcarrier_dds_test;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pin = 1'b1;
    logic [1:0]        mode = 2'b00;
    logic              pal = 1'b0;
    logic [31:0]       freq = 32'h0;
    logic [7:0]        ofs = 8'h0;
    logic              line_start = 1'b0;
    logic              field_start = 1'b0;
    logic signed [9:0] sin_out;
    logic signed [9:0] cos_out;

    int    errs = 0;
    int    checks = 0;
    string tag = "R11";
    bit    cmp_en = 1'b0;
    bit    finished = 1'b0;

    // reference model state
    logic [31:0] m_acc;
    logic [31:0] m_inc;
    logic [21:0] m_rinc;
    logic [21:0] p_inc;
    bit m_armed, m_pinq, m_pv, m_rx, m_seq, p_seq, p_clr;
    bit m_fire, m_rise, m_lclr, m_apply;
    bit q[$];
    int e_sin = 0;
    int e_cos = 0;
    int ph;

    always #2 clk = ~clk;

    subcarrier_dds uut (
        .clk(clk), .rst(rst), .rtc_pin(pin), .pin_mode(mode), .pal_mode(pal),
        .freq_word(freq), .phase_ofs(ofs), .line_start(line_start),
        .field_start(field_start), .sin_out(sin_out), .cos_out(cos_out)
    );

    function automatic int shape(input int p);
        int x, y, m;
        p = p & 1023;
        x = p & 255;
        y = ((p >> 8) & 1) ? 256 - x : x;
        m = (y * (512 - y)) / 256;
        return (p >= 512) ? -m : m;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_rinc = 0; p_inc = 0;
            m_armed = 0; m_pinq = 0; m_pv = 0; m_rx = 0;
            m_seq = 0; p_seq = 0; p_clr = 0;
            q.delete();
        end else begin
            ph = (int'(m_acc >> 22) + int'(ofs) * 4) & 1023;
            e_sin = shape(ph);
            e_cos = shape(ph + 256);
            if (pal && m_seq && mode == 2'b10) e_cos = -e_cos;
            m_inc   = (mode == 2'b10) ? {m_rinc, freq[9:0]} : freq;
            m_fire  = (mode == 2'b01) && m_armed && field_start;
            m_rise  = (mode == 2'b01) && !m_pinq && pin;
            m_apply = (mode == 2'b10) && line_start && m_pv;
            m_lclr  = m_apply && p_clr;
            if (m_fire || m_lclr) m_acc = 0;
            else m_acc = m_acc + m_inc;
            if (m_fire) m_armed = 0;
            if (m_rise) m_armed = 1;
            if (m_apply) begin
                m_rinc = p_inc; m_seq = p_seq; m_pv = 0;
            end
            if (m_rx) begin
                if (mode != 2'b10) m_rx = 0;
                else begin
                    q.push_back(pin);
                    if (q.size() == 136) begin
                        for (int k = 0; k < 22; k++) p_inc[k] = q[3 + 2 * k];
                        p_seq = q[47];
                        p_clr = q[49];
                        m_pv = 1; m_rx = 0;
                    end
                end
            end else if (mode == 2'b10 && m_pinq && !pin) begin
                m_rx = 1;
                q.delete();
                q.push_back(pin);
            end
            m_pinq = pin;
        end
    end

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            check("sin", int'(sin_out), e_sin);
            check("cos", int'(cos_out), e_cos);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_line();
        line_start = 1'b1; @(negedge clk); line_start = 1'b0;
    endtask

    task automatic pulse_field();
        field_start = 1'b1; @(negedge clk); field_start = 1'b0;
    endtask

    task automatic send_frame(input logic [21:0] finc, input bit s, input bit c, input int abort_at);
        pin = 1'b1; run(3);
        pin = 1'b0; run(2);
        for (int k = 0; k < 67; k++) begin
            if (k == abort_at) mode = 2'b00;
            if (k == abort_at + 1) mode = 2'b10;
            pin = (k < 22) ? finc[k] : (k == 22) ? s : (k == 23) ? c : k[0];
            run(2);
        end
        pin = 1'b1;
        run(3);
    endtask

    initial begin
        run(3);
        tag = "R11";
        check("sin in reset", int'(sin_out), 0);
        check("cos in reset", int'(cos_out), 0);
        freq = 32'h0123_4567;
        rst = 1'b0;
        cmp_en = 1'b1;
        // R1 R2 R3: free-running accumulator and shaping
        tag = "R1 R2 R3";
        run(300);
        ofs = 8'h40; run(80);
        ofs = 8'hC3; freq = 32'h2468_ACE1; run(120);
        // R4: idle encodings ignore pin and strobes
        tag = "R4";
        mode = 2'b11; freq = 32'h0765_4321;
        pin = 1'b0; run(3); pin = 1'b1; run(3);
        pulse_field(); pulse_line(); run(50);
        mode = 2'b00; pin = 1'b0; run(3); pin = 1'b1; pulse_field(); run(50);
        // R5: rephase on field strobe after pin rise
        tag = "R5";
        ofs = 8'h00; mode = 2'b01; freq = 32'h0123_4567; run(10);
        pulse_field(); run(10);
        pin = 1'b0; run(2); pin = 1'b1; run(5);
        freq = 32'h0; run(3);
        pulse_field();
        @(negedge clk);
        check("sin after rephase", int'(sin_out), 0);
        check("cos after rephase", int'(cos_out), 256);
        freq = 32'h0333_0000; run(20);
        pulse_field(); run(40);
        // R6 R7: line-locked frame, applied at line start
        tag = "R6 R7";
        mode = 2'b10; freq = 32'hFFFF_F3FF; run(5);
        send_frame(22'h2A_5A5A, 1'b0, 1'b0, 99);
        run(30);
        pulse_line(); run(120);
        // R8: clear flag zeroes the accumulator at the line start
        tag = "R8";
        freq = 32'h0;
        send_frame(22'h0, 1'b0, 1'b1, 99);
        pulse_line();
        @(negedge clk);
        check("sin after clear", int'(sin_out), 0);
        check("cos after clear", int'(cos_out), 256);
        run(20);
        // R9: inversion only when PAL
        tag = "R9";
        pal = 1'b1; freq = 32'h0000_0155;
        send_frame(22'h15_5555, 1'b1, 1'b0, 99);
        pulse_line(); run(100);
        pal = 1'b0; run(100);
        // R10: mode change drops the frame
        tag = "R10";
        send_frame(22'h3F_0F0F, 1'b0, 1'b1, 30);
        run(200);
        pulse_line(); run(100);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errs++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule